// File: doc/BRIEF.md
# Sidetone Filter Core with Streamed Coefficient Loader

This block feeds a small, filtered copy of a talker's own voice back into the earpiece path. A mono stream of signed 16-bit samples enters. When the core is switched on, each accepted sample goes into a delay line. The core convolves the delay line with a bank of signed 16-bit filter taps, scales the sum once by each of two per-channel gains, and hands out one rounded, saturated 16-bit sample per channel for mixing.

Software controls the core through a 32-bit register port with byte offsets. The whole tap bank is loaded through one data-port register, one word per tap. A 0-to-1 edge of a write-enable bit opens a load session. Each data-port write stores the next tap, and a read-only done flag rises once the last tap has been taken. The revision register and the two interrupt registers are placeholders only; the core raises no interrupt. A stored auto-idle bit drives an output that tells the clock controller it may gate the core.

The filter uses one shared multiplier and takes one tap per clock. A result appears NTAPS+1 clocks after its sample is accepted. Samples that arrive while a result is being computed are dropped.

Top module: `sidetone_core`

## Requirements
- R1: After reset, control (0x2C), sysconfig (0x10), gain (0x24) and both interrupt registers read 0. Revision (0x00) reads REV_ID. Both outputs and out_valid are 0.
- R2: Sysconfig bit 0, interrupt status (0x18), interrupt enable (0x1C) and gain (channel 0 gain in bits 15:0, channel 1 gain in bits 31:16) read back what was last written. clk_gate_ok follows sysconfig bit 0.
- R3: The control register has three bits: bit 0 is the filter enable, bit 1 is the tap write-enable and bit 2 is the load-done flag. Bits 0 and 1 read back as written. Bit 2 ignores writes, and all other bits read 0.
- R4: A write that takes control bit 1 from 0 to 1 resets the tap write index to 0 and clears the done flag. This also restarts a partial load.
- R5: While bit 1 is set, each data-port (0x28) write stores bits 15:0 as the next signed tap, from tap 0 upward. The done flag sets when tap NTAPS-1 is stored.
- R6: Data-port writes are ignored while bit 1 is clear or once the done flag is set.
- R7: Clearing bit 1 leaves the stored taps unchanged.
- R8: With the filter enabled, an smp_valid pulse is accepted when the core is idle. Exactly NTAPS+1 clocks later, out_valid pulses for one clock. Each channel output is then sat16(round((sum over k of tap[k]*x[n-k]) * gain / 2^15)), where rounding adds 2^14 before an arithmetic shift right by 15.
- R9: Results above 32767 output 32767, and results below -32768 output -32768.
- R10: While the enable bit is clear, both outputs and out_valid are 0 and the delay line is cleared, so samples from before a disable do not affect results after it.
- R11: smp_valid pulses that arrive while a result is still being computed are dropped and do not enter the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| smp_valid | input | 1 | Input sample strobe |
| smp_in | input | DW | Signed input sample |
| out_valid | output | 1 | One-clock pulse when new outputs are ready |
| out_ch0 | output | DW | Channel 0 sidetone sample |
| out_ch1 | output | DW | Channel 1 sidetone sample |
| clk_gate_ok | output | 1 | Auto-idle permission (sysconfig bit 0) |

## Verification
The bench restarts a load partway through. A core that does not reset the index on the write-enable edge would keep the stale taps and produce wrong filter sums. It sends extra data-port writes after the bank is full and with write-enable clear; a core that accepts them would overwrite taps or wrap the index. It injects samples while a result is being computed and after a disable. A core that shifts those samples in, or keeps its delay line across a disable, would give results that differ from the model. Gains of extreme sign and size with full-scale taps drive both channels into saturation, which exposes wrap-around in the rounding or clamping stage.

// File: rtl/st_pkg.sv
package st_pkg;
   localparam logic [7:0] A_REV    = 8'h00;
   localparam logic [7:0] A_SYSCFG = 8'h10;
   localparam logic [7:0] A_IRQST  = 8'h18;
   localparam logic [7:0] A_IRQEN  = 8'h1C;
   localparam logic [7:0] A_GAIN   = 8'h24;
   localparam logic [7:0] A_COEF   = 8'h28;
   localparam logic [7:0] A_CTRL   = 8'h2C;
   localparam int B_EN   = 0;
   localparam int B_WREN = 1;
   localparam int B_DONE = 2;
endpackage

// File: rtl/st_regs.sv
module st_regs #(
   parameter int          NTAPS  = 128,
   parameter int          DW     = 16,
   parameter int          GW     = 16,
   parameter logic [31:0] REV_ID = 32'h0000_0301,
   localparam int IW   = $clog2(NTAPS),
   localparam int CNTW = $clog2(NTAPS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [7:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [IW-1:0]        coef_rd_idx,
   output logic signed [DW-1:0] coef_rd_data,
   output logic                 st_en,
   output logic                 autoidle,
   output logic [1:0][GW-1:0]   gains,
   output logic                 wren,
   output logic                 done,
   output logic [CNTW-1:0]      idx
);
   import st_pkg::*;

   logic signed [DW-1:0] coef_q [NTAPS];
   logic [31:0]          irq_st_q, irq_en_q;
   logic                 wr_coef;

   assign wr_coef      = bus_wr && (bus_addr == A_COEF) && wren && !done;
   assign coef_rd_data = coef_q[coef_rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_en    <= 1'b0;
         autoidle <= 1'b0;
         gains    <= '0;
         wren     <= 1'b0;
         done     <= 1'b0;
         idx      <= '0;
         irq_st_q <= '0;
         irq_en_q <= '0;
         for (int i = 0; i < NTAPS; i++) coef_q[i] <= '0;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               A_SYSCFG: autoidle <= bus_wdata[0];
               A_IRQST:  irq_st_q <= bus_wdata;
               A_IRQEN:  irq_en_q <= bus_wdata;
               A_GAIN: begin
                  gains[0] <= bus_wdata[GW-1:0];
                  gains[1] <= bus_wdata[16 +: GW];
               end
               A_CTRL: begin
                  st_en <= bus_wdata[B_EN];
                  wren  <= bus_wdata[B_WREN];
                  if (bus_wdata[B_WREN] && !wren) begin
                     idx  <= '0;
                     done <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
         if (wr_coef) begin
            coef_q[idx[IW-1:0]] <= bus_wdata[DW-1:0];
            idx                 <= idx + 1'b1;
            if (idx == CNTW'(NTAPS - 1)) done <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_REV:    bus_rdata = REV_ID;
         A_SYSCFG: bus_rdata[0] = autoidle;
         A_IRQST:  bus_rdata = irq_st_q;
         A_IRQEN:  bus_rdata = irq_en_q;
         A_GAIN:   bus_rdata = {gains[1], gains[0]};
         A_CTRL: begin
            bus_rdata[B_EN]   = st_en;
            bus_rdata[B_WREN] = wren;
            bus_rdata[B_DONE] = done;
         end
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/st_fir_mac.sv
module st_fir_mac #(
   parameter int NTAPS = 128,
   parameter int DW    = 16,
   localparam int IW    = $clog2(NTAPS),
   localparam int PRODW = 2 * DW,
   localparam int ACC_W = 2 * DW + $clog2(NTAPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_en,
   input  logic                    smp_valid,
   input  logic signed [DW-1:0]    smp_in,
   output logic [IW-1:0]           coef_rd_idx,
   input  logic signed [DW-1:0]    coef_rd_data,
   output logic signed [ACC_W-1:0] acc,
   output logic                    acc_valid
);
   logic signed [DW-1:0]    dly_q [NTAPS];
   logic                    busy;
   logic [IW-1:0]           k;
   logic signed [PRODW-1:0] prod;

   assign coef_rd_idx = k;
   assign prod        = coef_rd_data * dly_q[k];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         k         <= '0;
         acc       <= '0;
         acc_valid <= 1'b0;
         for (int i = 0; i < NTAPS; i++) dly_q[i] <= '0;
      end else if (!st_en) begin
         busy      <= 1'b0;
         k         <= '0;
         acc       <= '0;
         acc_valid <= 1'b0;
         for (int i = 0; i < NTAPS; i++) dly_q[i] <= '0;
      end else begin
         acc_valid <= 1'b0;
         if (busy) begin
            acc <= acc + {{(ACC_W - PRODW){prod[PRODW-1]}}, prod};
            k   <= k + 1'b1;
            if (k == IW'(NTAPS - 1)) begin
               busy      <= 1'b0;
               acc_valid <= 1'b1;
            end
         end else if (smp_valid) begin
            dly_q[0] <= smp_in;
            for (int i = 1; i < NTAPS; i++) dly_q[i] <= dly_q[i-1];
            busy <= 1'b1;
            k    <= '0;
            acc  <= '0;
         end
      end
   end
endmodule

// File: rtl/st_gain_sat.sv
module st_gain_sat #(
   parameter int ACC_W = 39,
   parameter int GW    = 16,
   parameter int DW    = 16,
   parameter int NCH   = 2,
   localparam int PW   = ACC_W + GW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_en,
   input  logic signed [ACC_W-1:0] acc,
   input  logic                    acc_valid,
   input  logic [NCH-1:0][GW-1:0]  gains,
   output logic [NCH-1:0][DW-1:0]  outs,
   output logic                    out_valid
);
   localparam logic signed [PW-1:0] MAXV = $signed(PW'((64'd1 << (DW - 1)) - 64'd1));
   localparam logic signed [PW-1:0] MINV = -MAXV - 1;
   localparam logic signed [PW-1:0] RND  = $signed(PW'(64'd1 << (GW - 2)));

   logic signed [PW-1:0] acc_x;
   assign acc_x = {{GW{acc[ACC_W-1]}}, acc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_valid <= 1'b0;
      else               out_valid <= acc_valid && st_en;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [PW-1:0] g_x, p, sh;
      logic signed [DW-1:0] sat;
      always_comb begin
         g_x = {{ACC_W{gains[c][GW-1]}}, gains[c]};
         p   = acc_x * g_x;
         sh  = (p + RND) >>> (GW - 1);
         if (sh > MAXV)      sat = MAXV[DW-1:0];
         else if (sh < MINV) sat = MINV[DW-1:0];
         else                sat = sh[DW-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                outs[c] <= '0;
         else if (!st_en)           outs[c] <= '0;
         else if (acc_valid)        outs[c] <= sat;
      end
   end
endmodule

// File: rtl/sidetone_core.sv
module sidetone_core #(
   parameter int          NTAPS  = 128,
   parameter int          DW     = 16,
   parameter int          GW     = 16,
   parameter logic [31:0] REV_ID = 32'h0000_0301
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [7:0]    bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_in,
   output logic          out_valid,
   output logic [DW-1:0] out_ch0,
   output logic [DW-1:0] out_ch1,
   output logic          clk_gate_ok
);
   localparam int IW    = $clog2(NTAPS);
   localparam int CNTW  = $clog2(NTAPS + 1);
   localparam int ACC_W = 2 * DW + $clog2(NTAPS);

   if (NTAPS < 2 || DW < 2 || DW > 16 || GW < 2 || GW > 16) begin : g_bad_cfg
      $error("sidetone_core: unsupported parameter set");
   end

   logic                    st_en, autoidle, wren, done;
   logic [CNTW-1:0]         idx;
   logic [1:0][GW-1:0]      gains;
   logic [IW-1:0]           coef_rd_idx;
   logic signed [DW-1:0]    coef_rd_data;
   logic signed [ACC_W-1:0] acc;
   logic                    acc_valid;
   logic [1:0][DW-1:0]      outs;

   st_regs #(.NTAPS(NTAPS), .DW(DW), .GW(GW), .REV_ID(REV_ID)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .coef_rd_idx(coef_rd_idx), .coef_rd_data(coef_rd_data),
      .st_en(st_en), .autoidle(autoidle), .gains(gains),
      .wren(wren), .done(done), .idx(idx)
   );

   st_fir_mac #(.NTAPS(NTAPS), .DW(DW)) u_mac (
      .clk(clk), .rst_n(rst_n), .st_en(st_en), .smp_valid(smp_valid),
      .smp_in(smp_in), .coef_rd_idx(coef_rd_idx), .coef_rd_data(coef_rd_data),
      .acc(acc), .acc_valid(acc_valid)
   );

   st_gain_sat #(.ACC_W(ACC_W), .GW(GW), .DW(DW), .NCH(2)) u_gain (
      .clk(clk), .rst_n(rst_n), .st_en(st_en), .acc(acc),
      .acc_valid(acc_valid), .gains(gains), .outs(outs), .out_valid(out_valid)
   );

   assign out_ch0     = outs[0];
   assign out_ch1     = outs[1];
   assign clk_gate_ok = autoidle;
endmodule

// File: rtl/sidetone_core_chk.sv
module sidetone_core_chk #(
   parameter int NTAPS = 128,
   parameter int DW    = 16,
   localparam int CNTW = $clog2(NTAPS + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            st_en,
   input logic            wren,
   input logic            done,
   input logic [CNTW-1:0] idx,
   input logic            out_valid,
   input logic [DW-1:0]   out_ch0,
   input logic [DW-1:0]   out_ch1
);
   // R4
   wren_rise_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wren) |-> (!done && idx == '0));
   // R5
   done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (idx == CNTW'(NTAPS)));
   // R6
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= CNTW'(NTAPS));
   // R6
   idx_frozen_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(idx));
   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_en |=> (out_ch0 == '0 && out_ch1 == '0 && !out_valid));
   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
endmodule

bind sidetone_core sidetone_core_chk #(.NTAPS(NTAPS), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .st_en(st_en), .wren(wren), .done(done),
   .idx(idx), .out_valid(out_valid), .out_ch0(out_ch0), .out_ch1(out_ch1)
);

// File: tb/sidetone_core_tb.sv
module sidetone_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 128;
   localparam logic [31:0] REV = 32'h0000_0301;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_in = '0;
   logic        out_valid;
   logic [15:0] out_ch0, out_ch1;
   logic        clk_gate_ok;

   int checks = 0;
   int errors = 0;

   int coef_m [NT];
   int dly_m  [NT];
   int g0 = 0, g1 = 0;
   int m_idx = 0;
   bit m_wren = 0, m_done = 0, m_en = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sidetone_core dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
      .smp_in(smp_in), .out_valid(out_valid), .out_ch0(out_ch0),
      .out_ch1(out_ch1), .clk_gate_ok(clk_gate_ok)
   );

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int s16(logic [15:0] v);
      return int'($signed(v));
   endfunction

   function automatic int scale(longint acc, int g);
      longint p;
      p = acc * longint'(g);
      p = (p + 64'sd16384) >>> 15;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      return int'(p);
   endfunction

   function automatic longint fir_sum();
      longint s = 0;
      for (int k = 0; k < NT; k++) s += longint'(coef_m[k]) * longint'(dly_m[k]);
      return s;
   endfunction

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ctrl_write(logic [31:0] d);
      if (d[1] && !m_wren) begin m_idx = 0; m_done = 0; end
      m_wren = d[1];
      m_en = d[0];
      if (!m_en) for (int i = 0; i < NT; i++) dly_m[i] = 0;
      bus_write(8'h2C, d);
   endtask

   task automatic coef_write(logic [31:0] d);
      if (m_wren && !m_done) begin
         coef_m[m_idx] = s16(d[15:0]);
         m_idx++;
         if (m_idx == NT) m_done = 1;
      end
      bus_write(8'h28, d);
   endtask

   task automatic gain_write(logic [31:0] d);
      g0 = s16(d[15:0]);
      g1 = s16(d[31:16]);
      bus_write(8'h24, d);
   endtask

   // Sends one sample, optionally injects a dropped one during the busy window,
   // then checks timing and both channel values.
   task automatic run_sample(logic [15:0] v, bit inject, string req);
      int n = 0;
      bit seen = 0;
      @(negedge clk);
      smp_valid = 1'b1; smp_in = v;
      @(negedge clk);
      smp_valid = 1'b0;
      for (int i = NT-1; i > 0; i--) dly_m[i] = dly_m[i-1];
      dly_m[0] = s16(v);
      while (!seen && n < NT + 10) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (out_valid) seen = 1;
         else if (inject && n == 7) begin
            smp_valid = 1'b1; smp_in = 16'h7123;
            @(posedge clk); n++;
            #1 smp_valid = 1'b0;
            @(negedge clk);
            if (out_valid) seen = 1;
         end
      end
      // R8 latency
      chk(seen && n == NT + 1, "R8 latency", n, NT + 1);
      begin
         longint s = fir_sum();
         chk(s16(out_ch0) == scale(s, g0), req, s16(out_ch0), scale(s, g0));
         chk(s16(out_ch1) == scale(s, g1), req, s16(out_ch1), scale(s, g1));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd, w;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NT; i++) begin coef_m[i] = 0; dly_m[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(8'h2C, rd); chk(rd == 0, "R1 ctrl", rd, 0);
      bus_read(8'h00, rd); chk(rd == REV, "R1 rev", rd, REV);
      bus_read(8'h10, rd); chk(rd == 0, "R1 sysconfig", rd, 0);
      bus_read(8'h24, rd); chk(rd == 0, "R1 gain", rd, 0);
      bus_read(8'h18, rd); chk(rd == 0, "R1 irqstat", rd, 0);
      chk(out_ch0 == 0 && out_ch1 == 0 && !out_valid, "R1 outputs", out_ch0, 0);

      // R2 storage registers
      bus_write(8'h10, 32'h1);
      bus_read(8'h10, rd); chk(rd == 1, "R2 sysconfig", rd, 1);
      chk(clk_gate_ok == 1'b1, "R2 clk_gate_ok", clk_gate_ok, 1);
      w = $urandom; bus_write(8'h18, w);
      bus_read(8'h18, rd); chk(rd == w, "R2 irqstat", rd, w);
      w = $urandom; bus_write(8'h1C, w);
      bus_read(8'h1C, rd); chk(rd == w, "R2 irqen", rd, w);
      bus_write(8'h10, 32'h0);
      chk(clk_gate_ok == 1'b0, "R2 clk_gate_ok clear", clk_gate_ok, 0);

      // R3 done bit is read-only
      bus_write(8'h2C, 32'hFFFF_FFFC);
      bus_read(8'h2C, rd); chk(rd == 0, "R3 ro done", rd, 0);

      // R6 data write with write-enable clear is ignored
      coef_write(32'h0000_1111);

      // R5 full load
      ctrl_write(32'h2);
      bus_read(8'h2C, rd); chk(rd == 32'h2, "R4 load start", rd, 2);
      for (int i = 0; i < NT - 1; i++) coef_write($urandom);
      bus_read(8'h2C, rd); chk(rd[2] == 1'b0, "R5 not done early", rd[2], 0);
      coef_write($urandom);
      bus_read(8'h2C, rd); chk(rd == 32'h6, "R5 done", rd, 6);
      // R6 writes past the end are dropped
      for (int i = 0; i < 5; i++) coef_write($urandom);
      // R7 clear wren, taps remain
      ctrl_write(32'h0);
      coef_write(32'h0000_2222);
      ctrl_write(32'h1);
      bus_read(8'h2C, rd); chk(rd == 32'h5, "R3 ctrl readback", rd, 5);

      gain_write({16'(s16(16'h4000)), 16'h7FFF});
      bus_read(8'h24, rd); chk(rd == {16'h4000, 16'h7FFF}, "R2 gain", rd, 32'h40007FFF);

      // R8 random samples, R11 injected samples dropped
      for (int j = 0; j < 16; j++) begin
         if (j % 5 == 4) gain_write($urandom);
         run_sample(16'($urandom), (j % 3 == 1), (j % 3 == 1) ? "R11 dropped sample" : "R8 filter R7");
      end

      // R4 restart a partial load
      ctrl_write(32'h3);
      for (int i = 0; i < 10; i++) coef_write(32'h0000_0100);
      ctrl_write(32'h1);
      ctrl_write(32'h3);
      bus_read(8'h2C, rd); chk(rd[2] == 1'b0, "R4 restart clears done", rd[2], 0);
      for (int i = 0; i < NT; i++) coef_write(32'h0000_7FFF);
      bus_read(8'h2C, rd); chk(rd[2] == 1'b1, "R4 restart done", rd[2], 1);
      ctrl_write(32'h1);

      // R9 saturation both ways
      gain_write({16'h8000, 16'h7FFF});
      for (int j = 0; j < 3; j++) run_sample(16'h7FFF, 0, "R9 saturation");
      chk(s16(out_ch0) == 32767, "R9 pos clamp", s16(out_ch0), 32767);
      chk(s16(out_ch1) == -32768, "R9 neg clamp", s16(out_ch1), -32768);
      run_sample(16'h8000, 0, "R9 saturation neg");

      // R10 disable clears outputs and delay line
      ctrl_write(32'h0);
      @(negedge clk);
      chk(out_ch0 == 0 && out_ch1 == 0, "R10 disabled outputs", out_ch0, 0);
      @(negedge clk); smp_valid = 1'b1; smp_in = 16'h4000;
      @(negedge clk); smp_valid = 1'b0;
      repeat (NT + 3) @(negedge clk);
      chk(out_ch0 == 0 && !out_valid, "R10 ignored while off", out_ch0, 0);
      ctrl_write(32'h1);
      gain_write({16'h0100, 16'h0200});
      run_sample(16'h0003, 0, "R10 flushed delay line");
      run_sample(16'hFFF0, 0, "R10 flushed delay line 2");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule